// File: doc/BRIEF.md
# Synthesizer Output Divider and Debug Selector

This block is the digital back end of a frequency synthesizer. A fast clock, the oscillator clock of the loop, drives two dividers. The first is a power-of-two output divider that produces the main output clock. It has a synchronous enable gate, so switching the output on or off never shortens a pulse. The second is a programmable modulus counter that emits a narrow pulse once every M input ticks. In the full loop that pulse goes to the phase comparator as the feedback signal.

A 3-bit debug code picks one of eight views for a single debug pin. The views are:
- the serial configuration stream,
- two fixed levels,
- the reference clock,
- the modulus counter pulse,
- the output clock, and
- the output clock divided by four.

One code selects a bypass mode. In that mode, rising edges of a slow external serial clock advance both dividers in place of the fast clock. A board can then step the output clock by hand.

The serial clock is brought into the fast clock domain through a two-flop synchronizer. Every divider state change is a "tick": in normal mode a tick occurs on every fast clock edge, and in bypass mode only on a synchronized rising edge of the serial clock. The output divider produces a square wave whose high and low phases each last R ticks.

Top module: `clkgen_backend`

## Requirements
- R1: The output divide code selects R = 1, 2, 4 or 8 for codes 00, 01, 10 and 11. With the enable held high, `clk_out` is high for R ticks and then low for R ticks, repeating.
- R2: Restart rule. A change of the divide code, or entering or leaving bypass, clears the divider on the next fast clock edge. `clk_out` goes low at that edge and rises again after R further ticks.
- R3: The enable is sampled only while the divided clock is low. While the enable is off, `clk_out` stays low. Every high pulse of `clk_out` lasts exactly R ticks, however the enable is toggled.
- R4: For a modulus M of 2 or more, the counter output is high for one tick out of every M ticks. For M equal to 0 or 1, it stays high.
- R5: Debug code 001 drives `dbg_out` high. Debug code 101 drives `dbg_out` low.
- R6: Debug code 000 passes `shift_q` to `dbg_out`. Debug code 010 passes `ref_clk` to `dbg_out`.
- R7: Debug code 011 shows the modulus counter output on `dbg_out`. Debug code 100 shows `clk_out` on `dbg_out`.
- R8: Debug code 111 shows a 2-bit counter that advances on each rising edge of `clk_out`. `dbg_out` is its upper bit, so each of its high and low phases spans two `clk_out` periods.
- R9: Debug code 110 selects bypass:
  - Ticks come only from rising edges of `ser_clk`, after two synchronizer flops.
  - `clk_out` is the output of the output divider.
  - `dbg_out` is the modulus counter output.
  - The fast clock alone does not advance either divider.
- R10: During reset, `clk_out` is low, and the modulus counter output and the divide-by-four counter are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast clock from the loop oscillator; clocks all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, shown on the debug pin only |
| ser_clk | input | 1 | Slow serial clock; its rising edges are the ticks in bypass |
| m_mod | input | 9 | Modulus of the feedback counter |
| n_code | input | 2 | Output divide code (R = 2^code) |
| t_code | input | 3 | Debug view select |
| out_en | input | 1 | Active-high output enable |
| shift_q | input | 1 | Serial output of the configuration shift register |
| clk_out | output | 1 | Divided and gated output clock |
| dbg_out | output | 1 | Debug pin |

## Verification
The assertions check four behaviours on every cycle:
- the restart clears the divider on the edge after a code or source change;
- the enable latch only moves while the divided clock is low;
- the divider is frozen when no tick arrives;
- a modulus pulse is never followed by another at the next tick, for M of 2 or more.

The divide-by-four counter stepping once per output rising edge is also checked every cycle. The bench scenarios have to show the end-to-end behaviour:
- the pulse widths for each divide code and modulus;
- the full-width pulses under a toggling enable;
- the restart timing after a code change;
- each debug view;
- the hand-stepped waveform in bypass.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  localparam int MW = 9;            // modulus width
  localparam int NW = 2;            // divide code width
  localparam int TW = 3;            // debug code width
  localparam int PW = (1 << NW) - 1; // phase counter width
  localparam int RW = PW + 1;        // ratio width

  typedef enum logic [TW-1:0] {
    DBG_SHIFT  = 3'b000,
    DBG_HIGH   = 3'b001,
    DBG_REF    = 3'b010,
    DBG_MCNT   = 3'b011,
    DBG_OUT    = 3'b100,
    DBG_LOW    = 3'b101,
    DBG_BYPASS = 3'b110,
    DBG_QUART  = 3'b111
  } dbg_sel_e;

  // Ratio R = 2^code
  function automatic logic [RW-1:0] div_ratio(input logic [NW-1:0] code);
    return RW'(1) << code;
  endfunction

  // Last phase value before the divided clock toggles
  function automatic logic [PW-1:0] phase_last(input logic [NW-1:0] code);
    logic [RW-1:0] lim;
    lim = div_ratio(code) - RW'(1);
    return lim[PW-1:0];
  endfunction

  // Last count of the modulus counter; 0 and 1 collapse to pass-through
  function automatic logic [MW-1:0] mod_last(input logic [MW-1:0] m);
    return (m <= MW'(1)) ? '0 : m - MW'(1);
  endfunction
endpackage

// File: rtl/clkgen_tick_sel.sv
`timescale 1ns/1ps
module clkgen_tick_sel #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic bypass,
  output logic tick,
  output logic ser_edge
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], ser_clk};
  end

  assign ser_edge = sh[SYNC-1] & ~sh[SYNC];
  assign tick     = bypass ? ser_edge : 1'b1;

  // R9: a synchronized serial edge lasts one fast cycle
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_edge |=> !ser_edge);
endmodule

// File: rtl/clkgen_mod_cnt.sv
`timescale 1ns/1ps
module clkgen_mod_cnt
  import clkgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [MW-1:0] m_mod,
  output logic          m_out
);
  logic [MW-1:0] cnt;
  logic [MW-1:0] last;
  logic          wrap;

  assign last = mod_last(m_mod);
  assign wrap = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      m_out <= 1'b0;
    end else if (tick) begin
      cnt   <= wrap ? '0 : cnt + MW'(1);
      m_out <= wrap;
    end
  end

  // R4: for M >= 2 a pulse never repeats on the following tick
  assert_mod_pulse_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_mod >= MW'(2) && $stable(m_mod) && tick && m_out) |=> !m_out);
endmodule

// File: rtl/clkgen_out_div.sv
`timescale 1ns/1ps
module clkgen_out_div
  import clkgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bypass,
  input  logic [NW-1:0] n_code,
  input  logic          out_en,
  output logic          div_q,
  output logic          clk_out
);
  logic [PW-1:0] ph;
  logic [NW-1:0] n_prev;
  logic          byp_prev;
  logic          oe_q;
  logic          restart;

  assign restart = (n_code != n_prev) || (bypass != byp_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      div_q    <= 1'b0;
      n_prev   <= '0;
      byp_prev <= 1'b0;
    end else begin
      n_prev   <= n_code;
      byp_prev <= bypass;
      if (restart) begin
        ph    <= '0;
        div_q <= 1'b0;
      end else if (tick) begin
        if (ph >= phase_last(n_code)) begin
          ph    <= '0;
          div_q <= ~div_q;
        end else begin
          ph <= ph + PW'(1);
        end
      end
    end
  end

  // Enable latch moves only during the low phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_q <= 1'b0;
    else if (!div_q) oe_q <= out_en;
  end

  assign clk_out = div_q & oe_q;

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ph == '0 && !div_q));

  assert_enable_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(div_q));

  assert_no_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> ($stable(div_q) && $stable(ph)));
endmodule

// File: rtl/clkgen_dbg_sel.sv
`timescale 1ns/1ps
module clkgen_dbg_sel
  import clkgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] t_code,
  input  logic          shift_q,
  input  logic          ref_clk,
  input  logic          m_out,
  input  logic          clk_out,
  output logic          dbg_out
);
  logic [1:0] q4;
  logic       out_d;
  logic       out_rise;

  assign out_rise = clk_out & ~out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q4    <= '0;
      out_d <= 1'b0;
    end else begin
      out_d <= clk_out;
      if (out_rise) q4 <= q4 + 2'd1;
    end
  end

  always_comb begin
    case (dbg_sel_e'(t_code))
      DBG_SHIFT:  dbg_out = shift_q;
      DBG_HIGH:   dbg_out = 1'b1;
      DBG_REF:    dbg_out = ref_clk;
      DBG_MCNT:   dbg_out = m_out;
      DBG_OUT:    dbg_out = clk_out;
      DBG_LOW:    dbg_out = 1'b0;
      DBG_BYPASS: dbg_out = m_out;
      default:    dbg_out = q4[1];
    endcase
  end

  assert_quarter_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_rise |=> (q4 == $past(q4) + 2'd1));
endmodule

// File: rtl/clkgen_backend.sv
`timescale 1ns/1ps
module clkgen_backend
  import clkgen_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic          vco_clk,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          ser_clk,
  input  logic [MW-1:0] m_mod,
  input  logic [NW-1:0] n_code,
  input  logic [TW-1:0] t_code,
  input  logic          out_en,
  input  logic          shift_q,
  output logic          clk_out,
  output logic          dbg_out
);
  logic bypass;
  logic tick;
  logic ser_edge;
  logic m_out;
  logic div_q;

  assign bypass = (t_code == DBG_BYPASS);

  clkgen_tick_sel #(.SYNC(SYNC)) u_tick (
    .clk(vco_clk), .rst_n(rst_n), .ser_clk(ser_clk), .bypass(bypass),
    .tick(tick), .ser_edge(ser_edge)
  );

  clkgen_mod_cnt u_mcnt (
    .clk(vco_clk), .rst_n(rst_n), .tick(tick), .m_mod(m_mod), .m_out(m_out)
  );

  clkgen_out_div u_ndiv (
    .clk(vco_clk), .rst_n(rst_n), .tick(tick), .bypass(bypass),
    .n_code(n_code), .out_en(out_en), .div_q(div_q), .clk_out(clk_out)
  );

  clkgen_dbg_sel u_dbg (
    .clk(vco_clk), .rst_n(rst_n), .t_code(t_code), .shift_q(shift_q),
    .ref_clk(ref_clk), .m_out(m_out), .clk_out(clk_out), .dbg_out(dbg_out)
  );

  // R3: the gated output can only be high while the divided clock is
  assert_out_within_div_R3: assert property (@(posedge vco_clk) disable iff (!rst_n)
    clk_out |-> div_q);
endmodule

// File: tb/test_clkgen_backend.sv
`timescale 1ns/1ps
module test_clkgen_backend;
  logic       vco_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       ref_clk = 1'b0;
  logic       ser_clk = 1'b0;
  logic [8:0] m_mod   = 9'd4;
  logic [1:0] n_code  = 2'b00;
  logic [2:0] t_code  = 3'b011;
  logic       out_en  = 1'b1;
  logic       shift_q = 1'b0;
  logic       clk_out;
  logic       dbg_out;

  int vectors = 0;
  int errors  = 0;

  always #2.5 vco_clk = ~vco_clk;

  clkgen_backend i_clkgen_backend (
    .vco_clk(vco_clk), .rst_n(rst_n), .ref_clk(ref_clk), .ser_clk(ser_clk),
    .m_mod(m_mod), .n_code(n_code), .t_code(t_code), .out_en(out_en),
    .shift_q(shift_q), .clk_out(clk_out), .dbg_out(dbg_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? clk_out : dbg_out;
  endfunction

  // Waits for a rising edge of the chosen signal, then counts its high and low run
  task automatic measure(input int sel, input int exp_hi, input int exp_lo, input string req);
    logic v, pv;
    int   hi, lo, guard;
    pv = pick(sel); guard = 0;
    do begin
      @(negedge vco_clk); v = pick(sel); guard++;
      if (!pv && v) break;
      pv = v;
    end while (guard < 4000);
    hi = 0; lo = 0;
    while (v && hi < 4000) begin hi++; @(negedge vco_clk); v = pick(sel); end
    while (!v && lo < 4000) begin lo++; @(negedge vco_clk); v = pick(sel); end
    check(hi == exp_hi, {req, " high run"}, hi, exp_hi);
    check(lo == exp_lo, {req, " low run"}, lo, exp_lo);
  endtask

  task automatic run_reset;
    rst_n = 1'b0;
    t_code = 3'b011;
    repeat (3) @(negedge vco_clk);
    check(clk_out == 1'b0, "R10 clk_out in reset", clk_out, 0);
    check(dbg_out == 1'b0, "R10 modulus output in reset", dbg_out, 0);
    t_code = 3'b111;
    @(negedge vco_clk);
    check(dbg_out == 1'b0, "R10 quarter counter in reset", dbg_out, 0);
    t_code = 3'b011;
    rst_n = 1'b1;
    repeat (4) @(negedge vco_clk);
  endtask

  task automatic run_ratios;
    for (int c = 0; c < 4; c++) begin
      n_code = 2'(c);
      repeat (20) @(negedge vco_clk);
      measure(0, 1 << c, 1 << c, "R1 divide ratio");
    end
  endtask

  task automatic run_restart;
    int lo;
    n_code = 2'b11;
    repeat (40) @(negedge vco_clk);
    while (clk_out !== 1'b1) @(negedge vco_clk);
    n_code = 2'b01;
    @(negedge vco_clk);
    check(clk_out == 1'b0, "R2 cleared after code change", clk_out, 0);
    lo = 1;
    while (clk_out == 1'b0 && lo < 100) begin @(negedge vco_clk); if (!clk_out) lo++; end
    check(lo == 2, "R2 first low run after restart", lo, 2);
  endtask

  task automatic run_enable;
    int run, bad, zeros;
    n_code = 2'b10;
    repeat (20) @(negedge vco_clk);
    run = 0; bad = 0;
    for (int i = 0; i < 300; i++) begin
      if ((i % 7) == 3 || (i % 11) == 5) out_en = ~out_en;
      @(negedge vco_clk);
      if (clk_out) run++;
      else begin
        if (run != 0 && run != 4) bad++;
        run = 0;
      end
    end
    check(bad == 0, "R3 no shortened pulse under toggling enable", bad, 0);
    out_en = 1'b0;
    repeat (20) @(negedge vco_clk);
    zeros = 0;
    for (int i = 0; i < 40; i++) begin @(negedge vco_clk); if (!clk_out) zeros++; end
    check(zeros == 40, "R3 output held low when disabled", zeros, 40);
    out_en = 1'b1;
    measure(0, 4, 4, "R3 re-enabled pulse width");
  endtask

  task automatic run_modulus;
    int ones;
    t_code = 3'b011;
    m_mod = 9'd5;  repeat (20) @(negedge vco_clk);
    measure(1, 1, 4, "R4 modulus 5");
    m_mod = 9'd2;  repeat (20) @(negedge vco_clk);
    measure(1, 1, 1, "R4 modulus 2");
    m_mod = 9'd300; repeat (20) @(negedge vco_clk);
    measure(1, 1, 299, "R4 modulus 300");
    for (int mv = 0; mv < 2; mv++) begin
      m_mod = 9'(mv); repeat (5) @(negedge vco_clk);
      ones = 0;
      for (int i = 0; i < 20; i++) begin @(negedge vco_clk); if (dbg_out) ones++; end
      check(ones == 20, "R4 modulus 0/1 pass-through", ones, 20);
    end
    m_mod = 9'd4;
  endtask

  task automatic run_dbg_views;
    int same;
    t_code = 3'b001; @(negedge vco_clk);
    check(dbg_out == 1'b1, "R5 code 001 high", dbg_out, 1);
    t_code = 3'b101; @(negedge vco_clk);
    check(dbg_out == 1'b0, "R5 code 101 low", dbg_out, 0);
    t_code = 3'b000; shift_q = 1'b1; @(negedge vco_clk);
    check(dbg_out == 1'b1, "R6 shift view high", dbg_out, 1);
    shift_q = 1'b0; @(negedge vco_clk);
    check(dbg_out == 1'b0, "R6 shift view low", dbg_out, 0);
    t_code = 3'b010; ref_clk = 1'b1; @(negedge vco_clk);
    check(dbg_out == 1'b1, "R6 reference view high", dbg_out, 1);
    ref_clk = 1'b0; @(negedge vco_clk);
    check(dbg_out == 1'b0, "R6 reference view low", dbg_out, 0);
    n_code = 2'b01; t_code = 3'b100;
    repeat (10) @(negedge vco_clk);
    same = 0;
    for (int i = 0; i < 16; i++) begin @(negedge vco_clk); if (dbg_out == clk_out) same++; end
    check(same == 16, "R7 output view follows clk_out", same, 16);
    measure(1, 2, 2, "R7 output view width");
    n_code = 2'b00; t_code = 3'b111;
    repeat (20) @(negedge vco_clk);
    measure(1, 4, 4, "R8 quarter view");
  endtask

  task automatic run_bypass;
    int ones, stable_cnt;
    logic exp;
    m_mod = 9'd3; n_code = 2'b01; t_code = 3'b110; ser_clk = 1'b0;
    repeat (10) @(negedge vco_clk);
    stable_cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge vco_clk); if (!clk_out) stable_cnt++; end
    check(stable_cnt == 30, "R9 idle serial clock freezes output", stable_cnt, 30);
    ones = 0;
    for (int k = 1; k <= 9; k++) begin
      ser_clk = 1'b1; repeat (8) @(negedge vco_clk);
      ser_clk = 1'b0; repeat (8) @(negedge vco_clk);
      exp = ((k / 2) % 2) == 1;
      check(clk_out == exp, "R9 stepped output", clk_out, exp);
      if (dbg_out) ones++;
    end
    check(ones == 3, "R9 modulus pulses in bypass", ones, 3);
    t_code = 3'b011;
    repeat (10) @(negedge vco_clk);
  endtask

  initial begin
    run_reset();
    run_ratios();
    run_restart();
    run_enable();
    run_modulus();
    run_dbg_views();
    run_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule